// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Output Coding

This block is the digital half of a successive-approximation analog-to-digital converter. Once a start request is accepted it performs a binary search, one result bit per conversion clock and the most significant bit first. Each cycle it presents a trial code to an external capacitive DAC and takes one decision bit back from an external comparator. When the search ends, it formats the code according to the input configuration captured at start and presents the result.

Two configuration inputs select the coding. Single-ended operation always yields an unsigned result, whatever the polarity input says. Differential unipolar operation also yields straight binary, and an input below zero gives an all-zero code. Differential bipolar operation runs the search on an offset-binary DAC scale and returns a two's-complement result. The width is a parameter, 12 by default.

Top module: `sar_converter`

## Requirements
- R1: An accepted conversion holds `busy_o` high for exactly WIDTH cycles, starting the cycle after the start edge. `done_o` is then high for exactly one cycle, with `busy_o` low in that cycle.
- R2: The first trial code after an accepted start is midscale: only bit WIDTH-1 is set. In trial k (k = 0 .. WIDTH-1), bit WIDTH-1-k is set and every bit below it is clear.
- R3: `cmp_i` = 1 means the input is at or above the current trial and keeps the bit under test. `cmp_i` = 0 clears it. The final code is therefore the largest code whose trial level does not exceed the input.
- R4: With `single_ended_i` = 1, the result is unsigned straight binary, equal to the input clamped to 0 .. 2^WIDTH-1. This holds for either value of `bipolar_i`.
- R5: With `single_ended_i` = 0 and `bipolar_i` = 0, the result is straight binary, and a negative differential input gives all zeros.
- R6: With `single_ended_i` = 0 and `bipolar_i` = 1, the DAC code is offset binary, where code 2^(WIDTH-1) stands for zero input. The result is two's complement of the input clamped to -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R7: A start request while `busy_o` is high is ignored. The running conversion completes on its original schedule with its correct result.
- R8: The mode inputs are sampled on the accepting start edge. Changing them during a conversion changes neither the search nor the coding.
- R9: After reset, `busy_o`, `done_o`, `dac_code_o` and `result_o` are all zero.
- R10: `result_o` changes only in a cycle where `done_o` is high, and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above trial |
| single_ended_i | input | 1 | 1 = single-ended input, 0 = differential |
| bipolar_i | input | 1 | 1 = bipolar coding (differential only) |
| dac_code_o | output | WIDTH | Trial code driven to the DAC |
| busy_o | output | 1 | High while a conversion is running |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | WIDTH | Formatted conversion result |

## Verification
A wrong bit pointer or trial register shows up one cycle later on `dac_code_o`, as a trial code whose lowest set bit is out of place. It also produces a miscoded result at the next `done_o`. A corrupted coding choice appears only on `result_o`, at the end of the conversion. It is caught by sweeping the input across the whole range in every mode combination, including out-of-range values on both sides. Sequencing faults move `done_o` away from the cycle WIDTH edges after the start edge, and the bench catches them on the first conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    CODE_UNSIGNED = 1'b0,
    CODE_TWOS     = 1'b1
  } code_fmt_e;

  // Two's complement only for differential inputs with bipolar selected.
  function automatic code_fmt_e pick_fmt(input logic single_ended, input logic bipolar);
    return (!single_ended && bipolar) ? CODE_TWOS : CODE_UNSIGNED;
  endfunction

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  output logic         load_o,
  output logic         last_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] sel_o
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic         busy_q;
  logic         done_q;
  logic [W-1:0] sel_q;

  assign load_o = start_i && !busy_q;
  assign last_o = busy_q && sel_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        sel_q  <= TOP_BIT;
      end else if (busy_q) begin
        if (sel_q[0]) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          sel_q  <= '0;
        end else begin
          sel_q <= sel_q >> 1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         busy_i,
  input  logic [W-1:0] sel_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] resolved_o
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trial_q;

  // Code with the bit under test decided, before the next bit is tried.
  assign resolved_o = cmp_i ? trial_q : (trial_q & ~sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q <= '0;
    end else if (load_i) begin
      trial_q <= MID;
    end else if (busy_i) begin
      trial_q <= resolved_o | (sel_i >> 1);
    end
  end

  assign trial_o = trial_q;

endmodule

// File: rtl/sar_coder.sv
module sar_coder
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_i,
  input  code_fmt_e    fmt_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] result_o
);

  logic [W-1:0] result_q;
  logic [W-1:0] coded;

  // Offset binary to two's complement is a flip of the top bit.
  always_comb begin
    coded = code_i;
    if (fmt_i == CODE_TWOS) begin
      coded[W-1] = ~code_i[W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (capture_i) begin
      result_q <= coded;
    end
  end

  assign result_o = result_q;

endmodule

// File: rtl/sar_converter.sv
module sar_converter
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             single_ended_i,
  input  logic             bipolar_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  logic             load;
  logic             last;
  logic             busy;
  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] resolved;
  code_fmt_e        fmt_q;

  // Mode is frozen for the whole conversion.
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= CODE_UNSIGNED;
    end else if (load) begin
      fmt_q <= pick_fmt(single_ended_i, bipolar_i);
    end
  end

  sar_sequencer #(.W(WIDTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .last_o  (last),
    .busy_o  (busy),
    .done_o  (done_o),
    .sel_o   (sel)
  );

  sar_register #(.W(WIDTH)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .busy_i     (busy),
    .sel_i      (sel),
    .cmp_i      (cmp_i),
    .trial_o    (dac_code_o),
    .resolved_o (resolved)
  );

  sar_coder #(.W(WIDTH)) u_coder (
    .clk       (clk),
    .rst       (rst),
    .capture_i (last),
    .fmt_i     (fmt_q),
    .code_i    (resolved),
    .result_o  (result_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/sar_converter_checker.sv
module sar_converter_checker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);

  localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R1: done arrives after exactly WIDTH busy cycles
  p_busy_len_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (busy_run == WIDTH));

  // R1: done is a single-cycle pulse, never overlapping busy
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R2: accepted start loads midscale
  p_start_mid_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && dac_code_o == MID));

  // R7: start while busy never restarts the search
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> (done_o || dac_code_o != MID));

  // R10: result only moves alongside done
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

endmodule

bind sar_converter sar_converter_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .dac_code_o (dac_code_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/sar_converter_bench.sv
`timescale 1ns/1ps
module sar_converter_bench;

  localparam int W    = 8;
  localparam int FULL = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp = 1'b0;
  logic         single_ended = 1'b0;
  logic         bipolar = 1'b0;
  logic [W-1:0] dac_code;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  sar_converter #(.WIDTH(W)) u_sar_converter (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start),
    .cmp_i          (cmp),
    .single_ended_i (single_ended),
    .bipolar_i      (bipolar),
    .dac_code_o     (dac_code),
    .busy_o         (busy),
    .done_o         (done),
    .result_o       (result)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expected_code(input int vin, input bit twos);
    int c;
    if (twos) begin
      c = (vin < -HALF) ? -HALF : ((vin > HALF - 1) ? HALF - 1 : vin);
      return (c < 0) ? c + FULL : c;
    end
    return (vin < 0) ? 0 : ((vin > FULL - 1) ? FULL - 1 : vin);
  endfunction

  task automatic convert(input int vin, input bit se, input bit bip, input bit disturb);
    bit    twos = !se && bip;
    string tag  = disturb ? "R7 R8" : (se ? "R4" : (bip ? "R6" : "R5"));
    int    held;
    @(negedge clk);
    single_ended = se;
    bipolar      = bip;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W; i++) begin
      int d    = int'(dac_code);
      int step = 1 << (W - 1 - i);
      int lvl  = twos ? d - HALF : d;
      check(busy && !done, "R1 busy during search", {busy, done}, 2);
      check((d % step == 0) && ((d / step) % 2 == 1), "R2 trial bit order", d, step);
      if (i == 0) check(d == HALF, "R2 midscale first", d, HALF);
      cmp = (vin >= lvl);
      if (disturb && i == 2) begin
        start        = 1'b1;
        single_ended = ~se;
        bipolar      = ~bip;
      end
      if (disturb && i == 3) start = 1'b0;
      @(negedge clk);
    end
    check(done && !busy, "R1 done pulse", {busy, done}, 1);
    check(int'(result) == expected_code(vin, twos), {tag, " R3 result"},
          int'(result), expected_code(vin, twos));
    held         = int'(result);
    start        = 1'b0;
    single_ended = se;
    bipolar      = bip;
    @(negedge clk);
    check(!done && !busy, "R1 done one cycle", {busy, done}, 0);
    check(int'(result) == held, "R10 result held", int'(result), held);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy && !done, "R9 flags", {busy, done}, 0);
    check(dac_code == '0, "R9 dac", int'(dac_code), 0);
    check(result == '0, "R9 result", int'(result), 0);

    // R3 R4 R5 R6 sweep every mode over the full range plus overshoot
    for (int m = 0; m < 4; m++) begin
      for (int v = -FULL - 2; v <= FULL + 2; v++) begin
        convert(v, m[1], m[0], 1'b0);
      end
    end

    // R7 R8 extra start and mode flips mid-conversion
    for (int m = 0; m < 4; m++) begin
      convert(-HALF - 1, m[1], m[0], 1'b1);
      convert(-3, m[1], m[0], 1'b1);
      convert(0, m[1], m[0], 1'b1);
      convert(HALF + 5, m[1], m[0], 1'b1);
      convert(FULL - 1, m[1], m[0], 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule